// File: doc/BRIEF.md
# Fly-by DMA controller

This block moves bytes between peripherals and memory so that the processor does not have to. It has four channels. Each channel has a request input and an active-low acknowledge output. Software programs each channel through a small write port: a 16-bit memory address, a 16-bit byte count, and a mode word. When a programmed channel raises its request, the controller asks the processor for the bus with `hold`. Once `holda` comes back, it takes the bus and runs transfer cycles.

Every transfer is a single bus cycle. The controller drives the channel's memory address and pulls that channel's acknowledge low. It then strobes one memory line and the opposite I/O line together, so the peripheral and the memory exchange the byte directly on the data bus. A channel works in one of two modes. In cycle-stealing mode it gives the bus back after every byte. In burst mode it keeps the bus until its whole block is done. When a block finishes, the channel sets a sticky done flag, and the interrupt output is the OR of these flags.

Top module: `flyby_dma`

## Requirements
- R1: While reset is high and in the first cycle after it, `hold`, `bus_en` and `irq` are low, and all strobes and acknowledges are high.
- R2: A channel that is enabled, has a nonzero count and has its request high causes `hold` to rise. No bus output (`bus_en`, any acknowledge, any strobe) becomes active unless `holda` was high in the cycle before bus ownership starts.
- R3: A transfer takes exactly three clocks with the bus owned: a setup clock, a strobe clock and a release clock. In the setup clock the address and acknowledge are driven and all strobes are high. In the strobe clock the strobes are low as a pair: mode bit 1 set (memory to I/O) gives `mem_rd_n` with `io_wr_n`, and bit 1 clear gives `mem_wr_n` with `io_rd_n`. In the release clock all strobes are high again. The address and acknowledge stay the same for all three clocks.
- R4: At most one acknowledge is low at a time, and one is low exactly while `bus_en` is high.
- R5: Each transfer uses the channel's current address, and the address then increments. The increment wraps from 0xFFFF to 0x0000 and never carries into higher bits.
- R6: A channel programmed with count N makes exactly N transfers. It then clears its enable bit, sets its done flag and raises `irq`. Further requests on that channel are ignored.
- R7: When several channels are pending at arbitration, the lowest-numbered one is served first. Channel 0 has the highest priority.
- R8: In cycle-stealing mode (mode bit 2 clear), `hold` drops after each byte.
- R9: In burst mode (mode bit 2 set), `hold` stays high and the same channel keeps the bus until its count is exhausted. Requests from other channels, even higher-priority ones, wait until then.
- R10: If `holda` drops during a transfer, that transfer still completes. The bus is then released while `hold` stays high, and an unfinished burst resumes on the same channel when `holda` returns.
- R11: Writing the clear selector (code 3) for a channel clears that channel's done flag. `irq` stays high while any other done flag is set.
- R12: Requests on a channel that is disabled (mode bit 0 clear) or has a zero count are ignored: `hold` stays low.

Configuration selectors on `cfg_sel`: 0 = address, 1 = count, 2 = mode (bit 0 enable, bit 1 memory to I/O, bit 2 burst), 3 = clear done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel being configured |
| cfg_sel | input | 2 | Field selector: 0 address, 1 count, 2 mode, 3 clear done |
| cfg_wdata | input | 16 | Configuration write data |
| dreq | input | 4 | Per-channel transfer request, active high |
| holda | input | 1 | Bus grant from the processor |
| hold | output | 1 | Bus request to the processor |
| bus_en | output | 1 | High while the controller drives the address and strobe lines |
| addr | output | 16 | Memory address of the current transfer |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| irq | output | 1 | Completion interrupt: OR of the per-channel done flags |

## Verification
The assertions assume a processor that raises `holda` only while `hold` is high and lowers it whenever `hold` drops. They also assume software never rewrites the address, count or mode of a channel while that channel owns the bus. The bench's processor model returns `holda` after a random delay of zero to two clocks and withdraws it only when a test asks it to. Channels are reprogrammed only while idle, or when they are not the channel currently being served, so the stimulus stays inside those assumptions.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_MODE  = 2'd2;
  localparam logic [1:0] SEL_CLR   = 2'd3;

  localparam int MODE_EN    = 0;
  localparam int MODE_M2IO  = 1;
  localparam int MODE_BURST = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETUP,
    ST_STROBE,
    ST_REL
  } seq_st_t;
endpackage

// File: rtl/fbdma_chan.sv
module fbdma_chan import fbdma_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          ready,
  output logic          m2io,
  output logic          burst,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic          en;
  logic          last;

  assign last  = step && (cnt == CW'(1));
  assign ready = en && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      cnt   <= '0;
      en    <= 1'b0;
      m2io  <= 1'b0;
      burst <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (step) begin
        addr <= addr + 1'b1;
        cnt  <= cnt - 1'b1;
      end
      if (last) begin
        en   <= 1'b0;
        done <= 1'b1;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_ADDR:  addr <= wr_data[AW-1:0];
          SEL_COUNT: cnt  <= wr_data[CW-1:0];
          SEL_MODE: begin
            en    <= wr_data[MODE_EN];
            m2io  <= wr_data[MODE_M2IO];
            burst <= wr_data[MODE_BURST];
          end
          SEL_CLR:   if (!last) done <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R6: the done flag only appears once the block is exhausted and the channel disabled
  assert_done_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cnt == '0) && !en);

  // R12: the sequencer never steps a channel that is not ready
  assert_no_step_unready_R12: assert property (@(posedge clk) disable iff (rst)
    step |-> ready);
endmodule

// File: rtl/fbdma_arb.sv
module fbdma_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R7: the grant is pending and no lower-numbered channel is pending
  assert_grant_highest_R7: assert property (@(posedge clk) disable iff (rst)
    any |-> req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq import fbdma_pkg::*; #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int AW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  any,
  input  logic [IW-1:0]         gidx,
  input  logic                  holda,
  input  logic [N-1:0]          ready_v,
  input  logic [N-1:0]          m2io_v,
  input  logic [N-1:0]          burst_v,
  input  logic [N-1:0][AW-1:0]  addr_v,
  output logic [N-1:0]          step,
  output logic                  hold,
  output logic                  bus_en,
  output logic [AW-1:0]         addr,
  output logic [N-1:0]          dack_n,
  output logic                  mem_rd_n,
  output logic                  mem_wr_n,
  output logic                  io_rd_n,
  output logic                  io_wr_n
);
  seq_st_t       st, st_d;
  logic [IW-1:0] act, act_d;
  logic          lock, lock_d;
  logic          own_d, stb_d;

  always_comb begin
    st_d   = st;
    act_d  = act;
    lock_d = lock;
    unique case (st)
      ST_IDLE: begin
        lock_d = 1'b0;
        if (any) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (lock) begin
          if (holda) st_d = ST_SETUP;
        end else if (!any) begin
          st_d = ST_IDLE;
        end else if (holda) begin
          st_d  = ST_SETUP;
          act_d = gidx;
        end
      end
      ST_SETUP:  st_d = ST_STROBE;
      ST_STROBE: st_d = ST_REL;
      ST_REL: begin
        if (burst_v[act] && ready_v[act]) begin
          lock_d = 1'b1;
          st_d   = holda ? ST_SETUP : ST_REQ;
        end else begin
          lock_d = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign own_d = (st_d == ST_SETUP) || (st_d == ST_STROBE) || (st_d == ST_REL);
  assign stb_d = (st_d == ST_STROBE);
  assign step  = (st == ST_STROBE) ? (N'(1) << act) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      act      <= '0;
      lock     <= 1'b0;
      hold     <= 1'b0;
      bus_en   <= 1'b0;
      addr     <= '0;
      dack_n   <= '1;
      mem_rd_n <= 1'b1;
      mem_wr_n <= 1'b1;
      io_rd_n  <= 1'b1;
      io_wr_n  <= 1'b1;
    end else begin
      st       <= st_d;
      act      <= act_d;
      lock     <= lock_d;
      hold     <= (st_d != ST_IDLE);
      bus_en   <= own_d;
      addr     <= own_d ? addr_v[act_d] : '0;
      dack_n   <= own_d ? ~(N'(1) << act_d) : '1;
      mem_rd_n <= !(stb_d && m2io_v[act_d]);
      io_wr_n  <= !(stb_d && m2io_v[act_d]);
      mem_wr_n <= !(stb_d && !m2io_v[act_d]);
      io_rd_n  <= !(stb_d && !m2io_v[act_d]);
    end
  end

  // R2: ownership only starts after a grant, and only under a bus request
  assert_bus_needs_holda_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_en) |-> $past(holda));
  assert_bus_under_hold_R2: assert property (@(posedge clk) disable iff (rst)
    bus_en |-> hold);

  // R4: a single acknowledge, present exactly while the bus is owned
  assert_one_dack_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dack_n) && ((~dack_n != '0) == bus_en));

  // R3: strobes come in matched pairs, never both pairs
  assert_strobe_pairs_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_n == io_wr_n) && (mem_wr_n == io_rd_n) && (mem_rd_n || mem_wr_n));

  // R3: a strobe follows a setup clock with the same address
  assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_rd_n) || $fell(mem_wr_n)) |-> $past(bus_en) && $stable(addr) && $stable(dack_n));

  // R10: a started strobe is always followed by a release clock on the bus
  assert_cycle_completes_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_n && mem_wr_n) |=> bus_en && mem_rd_n && mem_wr_n && io_rd_n && io_wr_n);

  // R9: back-to-back owned clocks keep the same channel
  assert_burst_same_chan_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_en && $past(bus_en)) |-> $stable(dack_n));

  // R8: a stealing transfer gives the bus request back afterwards
  assert_steal_releases_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REL && !burst_v[act]) |=> !hold);
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW = (AW > CW) ? AW : CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_chan,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [NCH-1:0] dreq,
  input  logic           holda,
  output logic           hold,
  output logic           bus_en,
  output logic [AW-1:0]  addr,
  output logic [NCH-1:0] dack_n,
  output logic           mem_rd_n,
  output logic           mem_wr_n,
  output logic           io_rd_n,
  output logic           io_wr_n,
  output logic           irq
);
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0]         ch_ready, ch_m2io, ch_burst, ch_done, ch_step;
  logic                   any;
  logic [IW-1:0]          gidx;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    fbdma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we && (cfg_chan == IW'(i))),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .step    (ch_step[i]),
      .addr    (ch_addr[i]),
      .ready   (ch_ready[i]),
      .m2io    (ch_m2io[i]),
      .burst   (ch_burst[i]),
      .done    (ch_done[i])
    );
  end

  fbdma_arb #(.N(NCH), .IW(IW)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (dreq & ch_ready),
    .any (any),
    .idx (gidx)
  );

  fbdma_seq #(.N(NCH), .IW(IW), .AW(AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .any      (any),
    .gidx     (gidx),
    .holda    (holda),
    .ready_v  (ch_ready),
    .m2io_v   (ch_m2io),
    .burst_v  (ch_burst),
    .addr_v   (ch_addr),
    .step     (ch_step),
    .hold     (hold),
    .bus_en   (bus_en),
    .addr     (addr),
    .dack_n   (dack_n),
    .mem_rd_n (mem_rd_n),
    .mem_wr_n (mem_wr_n),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n)
  );

  assign irq = |ch_done;
endmodule

// File: tb/sim_flyby_dma.sv
module sim_flyby_dma;
  localparam int NCH = 4;
  localparam int LOGN = 512;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_chan;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic [3:0]  dreq;
  logic        holda;
  logic        hold, bus_en, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, irq;
  logic [15:0] addr;
  logic [3:0]  dack_n;

  always #10 clk = ~clk;

  flyby_dma u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dreq(dreq), .holda(holda), .hold(hold), .bus_en(bus_en),
    .addr(addr), .dack_n(dack_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench model of each channel
  logic [15:0] exp_addr [NCH];
  bit          exp_dir  [NCH];
  int          seen     [NCH];
  int          log_ch   [LOGN];
  int          log_hf   [LOGN];
  logic [15:0] log_addr [LOGN];
  int          nx = 0;
  int          hold_falls = 0;
  bit          cpu_block = 0;
  int          drop_at = -1;
  int          drop_phase = 0;

  // processor model: grants after a short random delay, releases when hold drops
  initial begin
    int dly;
    holda = 1'b0;
    dly = 0;
    forever begin
      @(negedge clk);
      if (cpu_block || !hold) begin
        holda = 1'b0;
        dly = $urandom_range(0, 2);
      end else if (!holda) begin
        if (dly == 0) holda = 1'b1;
        else dly--;
      end
    end
  end

  // bus monitor
  initial begin
    logic        p_hold, p_bus, p_idle;
    logic [15:0] p_addr;
    logic [3:0]  p_dack;
    bit          after_stb;
    int          c;
    p_hold = 0; p_bus = 0; p_idle = 1; p_addr = '0; p_dack = '1; after_stb = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (p_hold && !hold) hold_falls++;
        if (drop_phase == 2) begin
          chk("R10", "bus released after grant loss", {bus_en, hold, dack_n}, 6'b010000 | 6'h0F);
          drop_phase = 0;
        end else if (drop_phase == 1) begin
          drop_phase = 2;
        end
        if (!mem_rd_n || !mem_wr_n) begin
          c = -1;
          for (int i = 0; i < NCH; i++) if (!dack_n[i]) c = i;
          chk("R4", "acknowledges low during strobe", $countones(~dack_n), 1);
          if (c >= 0) begin
            chk("R5", "transfer address", addr, exp_addr[c]);
            exp_addr[c] = exp_addr[c] + 16'd1;
            chk("R3", "strobe pair direction", {!mem_rd_n, !io_wr_n, !mem_wr_n, !io_rd_n},
                exp_dir[c] ? 4'b1100 : 4'b0011);
            chk("R3", "setup clock before strobe",
                {p_bus, p_idle, p_addr == addr, p_dack == dack_n}, 4'hF);
            seen[c]++;
            if (nx < LOGN) begin
              log_ch[nx] = c; log_hf[nx] = hold_falls; log_addr[nx] = addr;
            end
            if (nx == drop_at) begin
              cpu_block = 1;
              drop_phase = 1;
            end
            nx++;
          end
          after_stb = 1;
        end else if (after_stb) begin
          chk("R3", "release clock keeps bus", {bus_en, mem_rd_n & mem_wr_n & io_rd_n & io_wr_n}, 2'b11);
          after_stb = 0;
        end
      end
      p_hold = hold; p_bus = bus_en; p_addr = addr; p_dack = dack_n;
      p_idle = mem_rd_n & mem_wr_n & io_rd_n & io_wr_n;
    end
  end

  task automatic cfg(input int ch, input int sel, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_chan = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input int a, input int n, input bit m2io, input bit burst);
    exp_addr[ch] = 16'(a);
    exp_dir[ch]  = m2io;
    seen[ch]     = 0;
    cfg(ch, 0, a);
    cfg(ch, 1, n);
    cfg(ch, 2, {burst, m2io, 1'b1});
  endtask

  task automatic wait_seen(input int ch, input int n, input string req);
    int t;
    t = 0;
    while (seen[ch] < n && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(req, "transfer count reached", seen[ch], n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt [NCH];
    int mask;
    void'($urandom(32'd4711));
    rst = 1; cfg_we = 0; cfg_chan = 0; cfg_sel = 0; cfg_wdata = 0; dreq = 0;
    for (int i = 0; i < NCH; i++) begin exp_addr[i] = '0; exp_dir[i] = 0; seen[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {hold, bus_en, irq, dack_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 11'h0FF);
    rst = 0;
    @(negedge clk);
    chk("R1", "outputs after reset", {hold, bus_en, irq, dack_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 11'h0FF);

    // R12: zero count and disabled channel are ignored
    prog(0, 16'h0100, 0, 0, 0);
    prog(1, 16'h0200, 5, 0, 0);
    cfg(1, 2, 0);
    dreq = 4'b0011;
    repeat (20) @(negedge clk);
    chk("R12", "hold for ignored requests", hold, 0);
    chk("R12", "transfers on ignored channels", seen[0] + seen[1], 0);
    dreq = 0;

    // R2: request without grant, then single transfer and completion (R6, R11)
    cpu_block = 1;
    prog(2, 16'h1234, 1, 1, 0);
    dreq[2] = 1;
    repeat (10) @(negedge clk);
    chk("R2", "hold while waiting", hold, 1);
    chk("R2", "bus idle without grant", {bus_en, dack_n, mem_rd_n, mem_wr_n}, 7'h3F);
    cpu_block = 0;
    wait_seen(2, 1, "R6");
    repeat (8) @(negedge clk);
    chk("R6", "irq after block", irq, 1);
    chk("R6", "finished channel no longer requests", hold, 0);
    chk("R6", "no extra transfer", seen[2], 1);
    cfg(2, 3, 1);
    @(negedge clk);
    chk("R11", "irq after clear", irq, 0);
    dreq = 0;

    // R7 / R8: two stealing channels requested together
    nx = 0;
    prog(1, 16'h4000, 3, 0, 0);
    prog(2, 16'h8000, 2, 1, 0);
    dreq = 4'b0110;
    wait_seen(1, 3, "R7");
    wait_seen(2, 2, "R7");
    for (int k = 0; k < 5; k++) chk("R7", "service order", log_ch[k], (k < 3) ? 1 : 2);
    for (int k = 0; k < 4; k++) chk("R8", "hold dropped between bytes", log_hf[k+1] > log_hf[k], 1);
    dreq = 0;
    repeat (6) @(negedge clk);
    chk("R11", "irq with two flags", irq, 1);
    cfg(1, 3, 1);
    @(negedge clk);
    chk("R11", "irq with one flag left", irq, 1);
    cfg(2, 3, 1);
    @(negedge clk);
    chk("R11", "irq with all cleared", irq, 0);

    // R9: burst on channel 3 is not interrupted by channel 0
    nx = 0;
    prog(3, 16'h2000, 6, 0, 1);
    dreq[3] = 1;
    wait_seen(3, 1, "R9");
    prog(0, 16'h0500, 2, 1, 0);
    dreq[0] = 1;
    wait_seen(3, 6, "R9");
    wait_seen(0, 2, "R9");
    for (int k = 0; k < 8; k++) chk("R9", "burst kept bus", log_ch[k], (k < 6) ? 3 : 0);
    for (int k = 1; k < 6; k++) chk("R9", "hold steady in burst", log_hf[k], log_hf[0]);
    dreq = 0;
    repeat (6) @(negedge clk);
    cfg(3, 3, 1);
    cfg(0, 3, 1);

    // R5: address wrap at the 16-bit boundary
    nx = 0;
    prog(1, 16'hFFFE, 4, 1, 1);
    dreq[1] = 1;
    wait_seen(1, 4, "R5");
    chk("R5", "third address wraps", log_addr[2], 16'h0000);
    chk("R5", "fourth address", log_addr[3], 16'h0001);
    dreq = 0;
    repeat (6) @(negedge clk);
    cfg(1, 3, 1);

    // R10: grant withdrawn mid burst
    nx = 0;
    drop_at = 1;
    prog(0, 16'h0A00, 5, 0, 1);
    dreq[0] = 1;
    wait_seen(0, 2, "R10");
    repeat (10) @(negedge clk);
    chk("R10", "no transfer without grant", seen[0], 2);
    chk("R10", "hold kept while suspended", hold, 1);
    drop_at = -1;
    cpu_block = 0;
    wait_seen(0, 5, "R10");
    for (int k = 0; k < 5; k++) chk("R10", "resumed on same channel", log_ch[k], 0);
    dreq = 0;
    repeat (6) @(negedge clk);
    cfg(0, 3, 1);

    // random rounds (R6)
    for (int r = 0; r < 6; r++) begin
      mask = $urandom_range(1, 15);
      for (int i = 0; i < NCH; i++) begin
        if (mask[i]) begin
          cnt[i] = $urandom_range(1, 6);
          prog(i, $urandom_range(0, 65535), cnt[i], 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
      end
      dreq = 4'(mask);
      for (int i = 0; i < NCH; i++) if (mask[i]) wait_seen(i, cnt[i], "R6");
      repeat (8) @(negedge clk);
      chk("R6", "irq after random round", irq, 1);
      for (int i = 0; i < NCH; i++) if (mask[i]) cfg(i, 3, 1);
      @(negedge clk);
      chk("R11", "irq cleared after round", irq, 0);
      dreq = 0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule